// File: doc/BRIEF.md
# Delayed-Transaction Target Controller

This block is the target side of a bridge that sits in front of a slow back-end device. When an initiator on the parallel bus issues a non-posted access, the controller does not stall the bus while the back-end works. It captures the request, ends the bus transaction with a retry, and performs the access on the back-end port on its own. The result is held in a single completion slot until the initiator repeats the identical request. The controller then finishes that repeat with the stored data, or with a target abort if the back-end reported a fatal error.

Only one delayed request is outstanding at a time. While the slot is occupied, any request that is not an exact repeat of the captured one is retried and leaves the slot untouched. A completion that nobody collects is dropped after a programmable number of clocks (32768 by default), so that a vanished initiator cannot block the slot forever.

The bus handshake is single data phase, and the bus-side signals are active high inside the block. In the address phase `frame_i` is high, with address, command and byte enables valid. In the data phase `irdy_i` is high and `wdata_i` is valid. The controller samples the data phase and drives its response in the following cycle. The response is held until it has been seen together with `irdy_i`.

Top module: `dtc_delayed_target`

## Requirements
- R1: While reset is applied and right after it is released, `trdy_o`, `stop_o`, `devsel_o` and `be_req_o` are low.
- R2: Only these command codes are claimed: 0000 (interrupt acknowledge), 0010 and 0011 (I/O read and write), 0110, 1100 and 1110 (memory reads), 1010 and 1011 (configuration read and write). Any other code gets no response (`trdy_o`, `stop_o`, `devsel_o` all stay low) and starts no back-end access.
- R3: A claimed request that arrives while the slot is empty is answered with retry, encoded as `stop_o`=1, `devsel_o`=1, `trdy_o`=0. The response appears one clock after the data-phase edge, which is well inside the 16-clock first-data-phase limit.
- R4: The captured address, command, byte enables and write data appear on the back-end port. `be_req_o` stays high with these values stable until `be_ack_i` is sampled high.
- R5: An exact repeat that arrives before the back-end has acknowledged is retried.
- R6: An exact repeat after the acknowledge completes with `trdy_o`=1, `devsel_o`=1 and `stop_o`=0. For a read command, `rdata_o` equals the acknowledged `be_rdata_i`. The slot is then free, so the same request again is retried and starts a new back-end access.
- R7: A request that differs from the captured one in address, command or byte enables is retried while the slot is occupied. It starts no back-end access, and the stored completion is still delivered to the later exact repeat.
- R8: For the write commands 0011 and 1011, the repeat must also carry the same write data; otherwise it is retried. A write completion returns status only, with `rdata_o`=0.
- R9: If `be_err_i` is high with the acknowledge, the exact repeat is ended with target abort (`stop_o`=1, `devsel_o`=0, `trdy_o`=0), and the slot is freed.
- R10: If no exact repeat is decided within DISCARD_CYCLES clocks after the acknowledge edge, the completion is dropped. A later identical request is retried and starts a new back-end access.
- R11: An exact repeat whose data-phase edge is the same edge on which the discard timer expires completes normally.
- R12: A response stays on the bus until it is sampled together with `irdy_i`, and is removed on that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | Address phase marker |
| irdy_i | input | 1 | Initiator ready for the data phase |
| addr_i | input | AW | Address, valid with frame_i |
| cmd_i | input | 4 | Command code, valid with frame_i |
| be_i | input | BEW | Byte enables, valid with frame_i |
| wdata_i | input | DW | Write data, valid in the data phase |
| trdy_o | output | 1 | Target ready: data transferred |
| stop_o | output | 1 | Target requests termination |
| devsel_o | output | 1 | Target claims the access |
| rdata_o | output | DW | Read data, valid with trdy_o |
| be_req_o | output | 1 | Back-end access request |
| be_addr_o | output | AW | Back-end address |
| be_cmd_o | output | 4 | Back-end command code |
| be_be_o | output | BEW | Back-end byte enables |
| be_wdata_o | output | DW | Back-end write data |
| be_ack_i | input | 1 | Back-end access done |
| be_rdata_i | input | DW | Back-end read data, valid with be_ack_i |
| be_err_i | input | 1 | Back-end fatal error, valid with be_ack_i |

## Verification
Two functions can fall on the same clock edge: the discard timer expiring, and the data-phase decision for an exact repeat. The bench releases the back-end acknowledge on a known edge and then counts clocks. It places the repeat's data-phase edge exactly on the expiry edge, and in a separate run one edge later. The first placement must still complete with the stored data. The second must be retried and must raise a new back-end request. A sweep over all sixteen command codes checks claiming, retry and completion, using read data computed in the bench from the address and command.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  localparam int CMD_W = 4;

  typedef enum logic [1:0] {
    RSP_RETRY = 2'd0,
    RSP_DONE  = 2'd1,
    RSP_ABORT = 2'd2
  } rsp_e;

  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_ISSUE = 2'd1,
    SLOT_READY = 2'd2
  } slot_e;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_DATA = 2'd1,
    BUS_RESP = 2'd2
  } bus_e;

  // commands that may be split into request and completion
  function automatic logic cmd_delayable(input logic [CMD_W-1:0] c);
    logic ok;
    case (c)
      4'b0000, 4'b0010, 4'b0011, 4'b0110,
      4'b1110, 4'b1100, 4'b1010, 4'b1011: ok = 1'b1;
      default:                            ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic cmd_is_write(input logic [CMD_W-1:0] c);
    return (c == 4'b0011) || (c == 4'b1011);
  endfunction

endpackage

// File: rtl/dtc_discard_timer.sv
module dtc_discard_timer #(
  parameter int LIMIT = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expire_o
);

  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d    = run_i ? cnt_q + 1'b1 : '0;
    expire_o = run_i && (cnt_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/dtc_bus_side.sv
module dtc_bus_side
  import dtc_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int BEW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_i,
  input  logic             irdy_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [BEW-1:0]   be_i,
  input  rsp_e             rsp_i,
  input  logic [DW-1:0]    rsp_data_i,
  output logic             decide_o,
  output logic [AW-1:0]    req_addr_o,
  output logic [CMD_W-1:0] req_cmd_o,
  output logic [BEW-1:0]   req_be_o,
  output logic             trdy_o,
  output logic             stop_o,
  output logic             devsel_o,
  output logic [DW-1:0]    rdata_o
);

  bus_e             st_q, st_d;
  logic             cap_en, out_load, out_clr;
  logic [AW-1:0]    addr_q;
  logic [CMD_W-1:0] cmd_q;
  logic [BEW-1:0]   be_q;
  logic             trdy_q, stop_q, devsel_q;
  logic [DW-1:0]    rdata_q;
  logic             trdy_n, stop_n, devsel_n;
  logic [DW-1:0]    rdata_n;

  // phase sequencing
  always_comb begin
    st_d     = st_q;
    cap_en   = 1'b0;
    decide_o = 1'b0;
    out_load = 1'b0;
    out_clr  = 1'b0;
    case (st_q)
      BUS_IDLE: begin
        if (frame_i) begin
          cap_en = 1'b1;
          st_d   = BUS_DATA;
        end
      end
      BUS_DATA: begin
        if (!cmd_delayable(cmd_q)) begin
          st_d = BUS_IDLE;
        end else if (irdy_i) begin
          decide_o = 1'b1;
          out_load = 1'b1;
          st_d     = BUS_RESP;
        end
      end
      BUS_RESP: begin
        if (irdy_i) begin
          out_clr = 1'b1;
          st_d    = BUS_IDLE;
        end
      end
      default: st_d = BUS_IDLE;
    endcase
  end

  // response encoding
  always_comb begin
    trdy_n   = (rsp_i == RSP_DONE);
    stop_n   = (rsp_i != RSP_DONE);
    devsel_n = (rsp_i != RSP_ABORT);
    rdata_n  = ((rsp_i == RSP_DONE) && !cmd_is_write(cmd_q)) ? rsp_data_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= BUS_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cmd_q  <= '0;
      be_q   <= '0;
    end else if (cap_en) begin
      addr_q <= addr_i;
      cmd_q  <= cmd_i;
      be_q   <= be_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trdy_q   <= 1'b0;
      stop_q   <= 1'b0;
      devsel_q <= 1'b0;
      rdata_q  <= '0;
    end else if (out_load) begin
      trdy_q   <= trdy_n;
      stop_q   <= stop_n;
      devsel_q <= devsel_n;
      rdata_q  <= rdata_n;
    end else if (out_clr) begin
      trdy_q   <= 1'b0;
      stop_q   <= 1'b0;
      devsel_q <= 1'b0;
      rdata_q  <= '0;
    end
  end

  assign req_addr_o = addr_q;
  assign req_cmd_o  = cmd_q;
  assign req_be_o   = be_q;
  assign trdy_o     = trdy_q;
  assign stop_o     = stop_q;
  assign devsel_o   = devsel_q;
  assign rdata_o    = rdata_q;

endmodule

// File: rtl/dtc_req_slot.sv
module dtc_req_slot
  import dtc_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int BEW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             decide_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [CMD_W-1:0] req_cmd_i,
  input  logic [BEW-1:0]   req_be_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             expire_i,
  output rsp_e             rsp_o,
  output logic [DW-1:0]    rsp_data_o,
  output logic             ready_o,
  output logic             be_req_o,
  output logic [AW-1:0]    be_addr_o,
  output logic [CMD_W-1:0] be_cmd_o,
  output logic [BEW-1:0]   be_be_o,
  output logic [DW-1:0]    be_wdata_o,
  input  logic             be_ack_i,
  input  logic [DW-1:0]    be_rdata_i,
  input  logic             be_err_i
);

  slot_e            st_q, st_d;
  logic             latch_en, fill_en, hit;
  logic [AW-1:0]    s_addr_q;
  logic [CMD_W-1:0] s_cmd_q;
  logic [BEW-1:0]   s_be_q;
  logic [DW-1:0]    s_wdata_q;
  logic [DW-1:0]    s_data_q;
  logic             s_err_q;

  // exact-repeat detection
  always_comb begin
    hit = (st_q != SLOT_EMPTY) &&
          (req_addr_i == s_addr_q) &&
          (req_cmd_i  == s_cmd_q)  &&
          (req_be_i   == s_be_q)   &&
          (!cmd_is_write(req_cmd_i) || (wdata_i == s_wdata_q));
  end

  always_comb begin
    if (st_q == SLOT_EMPTY)                rsp_o = RSP_RETRY;
    else if (hit && (st_q == SLOT_READY))  rsp_o = s_err_q ? RSP_ABORT : RSP_DONE;
    else                                   rsp_o = RSP_RETRY;
  end

  always_comb begin
    st_d     = st_q;
    latch_en = 1'b0;
    fill_en  = 1'b0;
    case (st_q)
      SLOT_EMPTY: begin
        if (decide_i) begin
          latch_en = 1'b1;
          st_d     = SLOT_ISSUE;
        end
      end
      SLOT_ISSUE: begin
        if (be_ack_i) begin
          fill_en = 1'b1;
          st_d    = SLOT_READY;
        end
      end
      SLOT_READY: begin
        // a collected completion wins over a same-edge expiry
        if ((decide_i && hit) || expire_i) st_d = SLOT_EMPTY;
      end
      default: st_d = SLOT_EMPTY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SLOT_EMPTY;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_addr_q  <= '0;
      s_cmd_q   <= '0;
      s_be_q    <= '0;
      s_wdata_q <= '0;
    end else if (latch_en) begin
      s_addr_q  <= req_addr_i;
      s_cmd_q   <= req_cmd_i;
      s_be_q    <= req_be_i;
      s_wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_data_q <= '0;
      s_err_q  <= 1'b0;
    end else if (fill_en) begin
      s_data_q <= be_rdata_i;
      s_err_q  <= be_err_i;
    end
  end

  assign rsp_data_o = s_data_q;
  assign ready_o    = (st_q == SLOT_READY);
  assign be_req_o   = (st_q == SLOT_ISSUE);
  assign be_addr_o  = s_addr_q;
  assign be_cmd_o   = s_cmd_q;
  assign be_be_o    = s_be_q;
  assign be_wdata_o = s_wdata_q;

endmodule

// File: rtl/dtc_delayed_target.sv
module dtc_delayed_target
  import dtc_pkg::*;
#(
  parameter int AW             = 32,
  parameter int DW             = 32,
  parameter int BEW            = 4,
  parameter int DISCARD_CYCLES = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_i,
  input  logic             irdy_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [BEW-1:0]   be_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             trdy_o,
  output logic             stop_o,
  output logic             devsel_o,
  output logic [DW-1:0]    rdata_o,
  output logic             be_req_o,
  output logic [AW-1:0]    be_addr_o,
  output logic [CMD_W-1:0] be_cmd_o,
  output logic [BEW-1:0]   be_be_o,
  output logic [DW-1:0]    be_wdata_o,
  input  logic             be_ack_i,
  input  logic [DW-1:0]    be_rdata_i,
  input  logic             be_err_i
);

  // reset: asserted at once, released on a clock edge
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic             decide;
  logic [AW-1:0]    req_addr;
  logic [CMD_W-1:0] req_cmd;
  logic [BEW-1:0]   req_be;
  rsp_e             rsp;
  logic [DW-1:0]    rsp_data;
  logic             slot_ready;
  logic             expire;

  dtc_bus_side #(.AW(AW), .DW(DW), .BEW(BEW)) u_bus (
    .clk        (clk),
    .rst_n      (rst_s2_q),
    .frame_i    (frame_i),
    .irdy_i     (irdy_i),
    .addr_i     (addr_i),
    .cmd_i      (cmd_i),
    .be_i       (be_i),
    .rsp_i      (rsp),
    .rsp_data_i (rsp_data),
    .decide_o   (decide),
    .req_addr_o (req_addr),
    .req_cmd_o  (req_cmd),
    .req_be_o   (req_be),
    .trdy_o     (trdy_o),
    .stop_o     (stop_o),
    .devsel_o   (devsel_o),
    .rdata_o    (rdata_o)
  );

  dtc_req_slot #(.AW(AW), .DW(DW), .BEW(BEW)) u_slot (
    .clk        (clk),
    .rst_n      (rst_s2_q),
    .decide_i   (decide),
    .req_addr_i (req_addr),
    .req_cmd_i  (req_cmd),
    .req_be_i   (req_be),
    .wdata_i    (wdata_i),
    .expire_i   (expire),
    .rsp_o      (rsp),
    .rsp_data_o (rsp_data),
    .ready_o    (slot_ready),
    .be_req_o   (be_req_o),
    .be_addr_o  (be_addr_o),
    .be_cmd_o   (be_cmd_o),
    .be_be_o    (be_be_o),
    .be_wdata_o (be_wdata_o),
    .be_ack_i   (be_ack_i),
    .be_rdata_i (be_rdata_i),
    .be_err_i   (be_err_i)
  );

  dtc_discard_timer #(.LIMIT(DISCARD_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_s2_q),
    .run_i    (slot_ready),
    .expire_o (expire)
  );

endmodule

// File: rtl/dtc_checker.sv
module dtc_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irdy_i,
  input logic          trdy_o,
  input logic          stop_o,
  input logic          devsel_o,
  input logic          be_req_o,
  input logic          be_ack_i,
  input logic [AW-1:0] be_addr_o,
  input logic [3:0]    be_cmd_o
);

  // R3 / R9: data transfer and termination never share a cycle
  p_no_trdy_with_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(trdy_o && stop_o));

  // R6: a completion is always claimed
  p_done_claimed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trdy_o |-> devsel_o);

  // R4: request held with stable fields until acknowledged
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req_o && !be_ack_i) |=> (be_req_o && $stable(be_addr_o) && $stable(be_cmd_o)));

  // R12: response held while the initiator is not ready
  p_resp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((trdy_o || stop_o) && !irdy_i) |=> ($stable(trdy_o) && $stable(stop_o) && $stable(devsel_o)));

  // R12: response removed once seen with the initiator ready
  p_resp_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((trdy_o || stop_o) && irdy_i) |=> (!trdy_o && !stop_o && !devsel_o));

endmodule

bind dtc_delayed_target dtc_checker #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irdy_i    (irdy_i),
  .trdy_o    (trdy_o),
  .stop_o    (stop_o),
  .devsel_o  (devsel_o),
  .be_req_o  (be_req_o),
  .be_ack_i  (be_ack_i),
  .be_addr_o (be_addr_o),
  .be_cmd_o  (be_cmd_o)
);

// File: tb/sim_dtc_delayed_target.sv
module sim_dtc_delayed_target;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int BEW = 4;
  localparam int LIMIT = 40;

  localparam int K_NONE  = 0;
  localparam int K_RETRY = 1;
  localparam int K_DONE  = 2;
  localparam int K_ABORT = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic frame, irdy;
  logic [AW-1:0] addr;
  logic [3:0] cmd;
  logic [BEW-1:0] byen;
  logic [DW-1:0] wdata;
  logic trdy, stop, devsel;
  logic [DW-1:0] rdata;
  logic be_req;
  logic [AW-1:0] be_addr;
  logic [3:0] be_cmd;
  logic [BEW-1:0] be_be;
  logic [DW-1:0] be_wdata;
  logic be_ack;
  logic [DW-1:0] be_rdata;
  logic be_err;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtc_delayed_target #(.AW(AW), .DW(DW), .BEW(BEW), .DISCARD_CYCLES(LIMIT)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_i(frame), .irdy_i(irdy),
    .addr_i(addr), .cmd_i(cmd), .be_i(byen), .wdata_i(wdata),
    .trdy_o(trdy), .stop_o(stop), .devsel_o(devsel), .rdata_o(rdata),
    .be_req_o(be_req), .be_addr_o(be_addr), .be_cmd_o(be_cmd),
    .be_be_o(be_be), .be_wdata_o(be_wdata),
    .be_ack_i(be_ack), .be_rdata_i(be_rdata), .be_err_i(be_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int kind_now();
    if (trdy && devsel && !stop)       return K_DONE;
    if (stop && devsel && !trdy)       return K_RETRY;
    if (stop && !devsel && !trdy)      return K_ABORT;
    if (!stop && !devsel && !trdy)     return K_NONE;
    return 9;
  endfunction

  function automatic logic [DW-1:0] exp_data(input logic [AW-1:0] a, input logic [3:0] c);
    return a ^ {c, 4'h0} ^ 8'h3C;
  endfunction

  function automatic bit tb_elig(input logic [3:0] c);
    return c inside {4'b0000, 4'b0010, 4'b0011, 4'b0110,
                     4'b1110, 4'b1100, 4'b1010, 4'b1011};
  endfunction

  function automatic bit tb_wr(input logic [3:0] c);
    return (c == 4'b0011) || (c == 4'b1011);
  endfunction

  // one bus transaction: address phase, data phase, wait for response
  task automatic txn(input logic [AW-1:0] a, input logic [3:0] c,
                     input logic [BEW-1:0] b, input logic [DW-1:0] w,
                     input int exp_kind, input logic [DW-1:0] exp_rd,
                     input string req);
    int k;
    int lat;
    @(negedge clk);
    frame = 1'b1; addr = a; cmd = c; byen = b;
    @(negedge clk);
    frame = 1'b0; irdy = 1'b1; wdata = w;
    k = K_NONE;
    lat = 0;
    while (lat < 4 && k == K_NONE) begin
      @(negedge clk);
      lat++;
      k = kind_now();
    end
    chk(k == exp_kind, req, "response kind", k, exp_kind);
    if (k != K_NONE) begin
      chk(lat == 1, "R3", "response latency", lat, 1);
      if (k == K_DONE)
        chk(rdata == exp_rd, req, "read data", int'(rdata), int'(exp_rd));
      @(negedge clk);
      chk(!trdy && !stop && !devsel, "R12", "response removed",
          {trdy, stop, devsel}, 0);
    end
    irdy = 1'b0;
  endtask

  // back-end model: acknowledge the pending request
  task automatic do_ack(input logic [AW-1:0] a, input logic [3:0] c,
                        input logic [BEW-1:0] b, input logic [DW-1:0] w,
                        input logic [DW-1:0] d, input logic e, input string req);
    int n = 0;
    while (!be_req && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(be_req, req, "back-end request", be_req, 1);
    chk(be_addr == a, "R4", "back-end address", be_addr, a);
    chk(be_cmd == c, "R4", "back-end command", be_cmd, c);
    chk(be_be == b, "R4", "back-end byte enables", be_be, b);
    if (tb_wr(c)) chk(be_wdata == w, "R4", "back-end write data", be_wdata, w);
    be_ack = 1'b1; be_rdata = d; be_err = e;
    @(negedge clk);
    be_ack = 1'b0; be_err = 1'b0; be_rdata = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    frame = 1'b0; irdy = 1'b0; addr = '0; cmd = '0; byen = '0; wdata = '0;
    be_ack = 1'b0; be_rdata = '0; be_err = 1'b0;
    repeat (3) @(negedge clk);
    chk(!trdy && !stop && !devsel && !be_req, "R1", "outputs in reset",
        {trdy, stop, devsel, be_req}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!trdy && !stop && !devsel && !be_req, "R1", "outputs after reset",
        {trdy, stop, devsel, be_req}, 0);

    // R2 / R3 / R6 / R8: sweep every command code
    for (int c = 0; c < 16; c++) begin
      logic [3:0] cc;
      logic [AW-1:0] aa;
      logic [BEW-1:0] bb;
      logic [DW-1:0] ww;
      cc = 4'(c);
      aa = 8'(16 + c * 5);
      bb = 4'hF ^ cc;
      ww = 8'(c * 7 + 1);
      if (tb_elig(cc)) begin
        txn(aa, cc, bb, ww, K_RETRY, '0, "R3");
        do_ack(aa, cc, bb, ww, exp_data(aa, cc), 1'b0, "R4");
        txn(aa, cc, bb, ww, K_DONE, tb_wr(cc) ? 8'h00 : exp_data(aa, cc),
            tb_wr(cc) ? "R8" : "R6");
        chk(!be_req, "R6", "no request after completion", be_req, 0);
      end else begin
        txn(aa, cc, bb, ww, K_NONE, '0, "R2");
        chk(!be_req, "R2", "no back-end access for unclaimed", be_req, 0);
      end
    end

    // R5 / R7: non-matching and early repeats
    txn(8'h44, 4'b0110, 4'h3, 8'h00, K_RETRY, '0, "R3");
    txn(8'h44, 4'b0110, 4'h3, 8'h00, K_RETRY, '0, "R5");
    txn(8'h45, 4'b0110, 4'h3, 8'h00, K_RETRY, '0, "R7");
    chk(be_addr == 8'h44, "R7", "captured address kept", be_addr, 8'h44);
    do_ack(8'h44, 4'b0110, 4'h3, 8'h00, 8'h9E, 1'b0, "R4");
    txn(8'h44, 4'b1110, 4'h3, 8'h00, K_RETRY, '0, "R7");
    txn(8'h44, 4'b0110, 4'h7, 8'h00, K_RETRY, '0, "R7");
    chk(!be_req, "R7", "mismatch starts no access", be_req, 0);
    txn(8'h44, 4'b0110, 4'h3, 8'h00, K_DONE, 8'h9E, "R7");
    // R6: slot freed, identical request starts over
    txn(8'h44, 4'b0110, 4'h3, 8'h00, K_RETRY, '0, "R6");
    do_ack(8'h44, 4'b0110, 4'h3, 8'h00, 8'h11, 1'b0, "R6");
    txn(8'h44, 4'b0110, 4'h3, 8'h00, K_DONE, 8'h11, "R6");

    // R8: write data must match
    txn(8'h20, 4'b0011, 4'hF, 8'hA5, K_RETRY, '0, "R8");
    do_ack(8'h20, 4'b0011, 4'hF, 8'hA5, 8'hFF, 1'b0, "R8");
    txn(8'h20, 4'b0011, 4'hF, 8'hA4, K_RETRY, '0, "R8");
    txn(8'h20, 4'b0011, 4'hF, 8'hA5, K_DONE, 8'h00, "R8");

    // R9: back-end error gives target abort, slot freed
    txn(8'h30, 4'b1010, 4'h1, 8'h00, K_RETRY, '0, "R9");
    do_ack(8'h30, 4'b1010, 4'h1, 8'h00, 8'h77, 1'b1, "R9");
    txn(8'h30, 4'b1010, 4'h1, 8'h00, K_ABORT, '0, "R9");
    txn(8'h30, 4'b1010, 4'h1, 8'h00, K_RETRY, '0, "R9");
    do_ack(8'h30, 4'b1010, 4'h1, 8'h00, 8'h77, 1'b0, "R9");
    txn(8'h30, 4'b1010, 4'h1, 8'h00, K_DONE, 8'h77, "R9");

    // R10: decision one edge after expiry -> dropped
    txn(8'h50, 4'b0010, 4'h2, 8'h00, K_RETRY, '0, "R10");
    do_ack(8'h50, 4'b0010, 4'h2, 8'h00, 8'h5D, 1'b0, "R10");
    repeat (LIMIT - 2) @(negedge clk);
    txn(8'h50, 4'b0010, 4'h2, 8'h00, K_RETRY, '0, "R10");
    chk(be_req, "R10", "new back-end access after discard", be_req, 1);
    do_ack(8'h50, 4'b0010, 4'h2, 8'h00, 8'h62, 1'b0, "R10");
    txn(8'h50, 4'b0010, 4'h2, 8'h00, K_DONE, 8'h62, "R10");

    // R11: decision on the expiry edge -> still completes
    txn(8'h60, 4'b1100, 4'h8, 8'h00, K_RETRY, '0, "R11");
    do_ack(8'h60, 4'b1100, 4'h8, 8'h00, 8'hC3, 1'b0, "R11");
    repeat (LIMIT - 3) @(negedge clk);
    txn(8'h60, 4'b1100, 4'h8, 8'h00, K_DONE, 8'hC3, "R11");
    chk(!be_req, "R11", "no new access after same-edge completion", be_req, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule